// File: doc/BRIEF.md
# Parallel XOR Bank Mapper

This block turns a set of element indices into memory bank numbers for a memory split into 2^BANK_W banks. It works on one full lane group at a time: every clock in which `in_valid` is high, it takes 2^BANK_W indices of IDX_W bits each, one per lane. Each bank number comes from XOR parities over long runs of index bits, plus pairwise XORs of index bits. With these formulas, the operand groups an in-place transform touches in one cycle spread over all banks with no collisions.

There are two forms of the formula. The natural form serves one frame. The mirrored form serves the next frame, whose data is stored in bit-reversed order. The form is picked per group by `rev_sel`. Each result is registered. A collision flag goes high whenever two lanes of a result land in the same bank, so that a faulty address sequence can be caught.

Top module: `bank_xor_mapper`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted group, `out_valid` is 0, `dup_flag` is 0 and every bank output is 0.
- R2: In both forms, bank bit 0 equals index bit 0.
- R3: Natural form (`rev_sel`=0): bank bit 1 is the XOR of index bits 1 up to IDX_W-BANK_W+1.
- R4: Natural form: bank bit i, for 2 ≤ i ≤ BANK_W-2, is index bit i XOR index bit IDX_W-BANK_W+i.
- R5: Natural form: bank bit BANK_W-1 is the XOR of index bits BANK_W-1 up to IDX_W-1.
- R6: Mirrored form (`rev_sel`=1): bank bit 1 is the XOR of index bits BANK_W-1 up to IDX_W-1.
- R7: Mirrored form: bank bit i, for 2 ≤ i ≤ BANK_W-2, is index bit IDX_W-i XOR index bit BANK_W-i.
- R8: Mirrored form: bank bit BANK_W-1 is the XOR of index bits 1 up to IDX_W-BANK_W+1.
- R9: A group accepted on a rising edge with `in_valid`=1 appears on `bank_flat` with `out_valid`=1 exactly one cycle later. `out_valid` is 0 after any edge with `in_valid`=0, and `bank_flat` then holds its previous value. Lane k uses bits [k*W+W-1 : k*W] of each flat bus.
- R10: `dup_flag` is 1 exactly when `out_valid` is 1 and at least two lanes of `bank_flat` carry equal bank numbers.
- R11: For any group whose lanes vary only index bits 0..BANK_W-3, IDX_W-2 and IDX_W-1, and share all other bits, the lanes map to pairwise distinct banks in both forms, so `dup_flag` stays 0.
- R12: `rev_sel` is sampled with each group, so back-to-back groups may use different forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept a lane group this cycle |
| rev_sel | input | 1 | 0 selects the natural form, 1 the mirrored form |
| idx_flat | input | LANES*IDX_W | Packed element indices, lane 0 in the low bits |
| out_valid | output | 1 | Bank group valid |
| bank_flat | output | LANES*BANK_W | Packed bank numbers, lane 0 in the low bits |
| dup_flag | output | 1 | Two or more lanes share a bank in the current result |

## Verification
Every result is due exactly one cycle after the edge that accepts its group. `dup_flag` is due in the same cycle as the banks it describes. The driver pushes one expected group per accepted input into a queue. The monitor samples on the falling edge and pops one entry only in cycles where `out_valid` is high, so a late, early or missing result shows up as a mismatch or as an unexpected valid. In cycles with `out_valid` low, the monitor checks that the bank outputs still hold the last popped value.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
  typedef enum logic {
    FORM_NAT = 1'b0,
    FORM_REV = 1'b1
  } form_e;

  localparam int unsigned DEF_IDX_W  = 8;
  localparam int unsigned DEF_BANK_W = 4;
endpackage

// File: rtl/bxm_lane_hash.sv
module bxm_lane_hash #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BANK_W = 4
) (
  input  logic              rev,
  input  logic [IDX_W-1:0]  idx,
  output logic [BANK_W-1:0] bank
);
  localparam int unsigned LO_TOP = IDX_W - BANK_W + 1;
  localparam int unsigned HI_BOT = BANK_W - 1;

  logic par_lo;
  logic par_hi;

  assign par_lo = ^idx[LO_TOP:1];
  assign par_hi = ^idx[IDX_W-1:HI_BOT];

  for (genvar j = 0; j < BANK_W; j++) begin : g_bit
    if (j == 0) begin : g_b0
      assign bank[j] = idx[0];
    end else if (j == 1) begin : g_b1
      assign bank[j] = rev ? par_hi : par_lo;
    end else if (j == BANK_W - 1) begin : g_btop
      assign bank[j] = rev ? par_lo : par_hi;
    end else begin : g_bmid
      logic nat_bit;
      logic rev_bit;
      assign nat_bit = idx[j] ^ idx[IDX_W-BANK_W+j];
      assign rev_bit = idx[IDX_W-j] ^ idx[BANK_W-j];
      assign bank[j] = rev ? rev_bit : nat_bit;
    end
  end
endmodule

// File: rtl/bxm_pair_cmp.sv
module bxm_pair_cmp #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned LANES  = 16
) (
  input  logic [LANES*BANK_W-1:0] banks,
  output logic                    any_eq
);
  localparam int unsigned PAIRS = LANES * (LANES - 1) / 2;

  logic [PAIRS-1:0] eq_vec;

  for (genvar i = 1; i < LANES; i++) begin : g_row
    for (genvar j = 0; j < i; j++) begin : g_col
      localparam int unsigned PI = i * (i - 1) / 2 + j;
      assign eq_vec[PI] = (banks[i*BANK_W +: BANK_W] == banks[j*BANK_W +: BANK_W]);
    end
  end

  assign any_eq = |eq_vec;
endmodule

// File: rtl/bank_xor_mapper.sv
module bank_xor_mapper #(
  parameter int unsigned IDX_W  = bxm_pkg::DEF_IDX_W,
  parameter int unsigned BANK_W = bxm_pkg::DEF_BANK_W,
  localparam int unsigned LANES = 1 << BANK_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    rev_sel,
  input  logic [LANES*IDX_W-1:0]  idx_flat,
  output logic                    out_valid,
  output logic [LANES*BANK_W-1:0] bank_flat,
  output logic                    dup_flag
);
  import bxm_pkg::*;

  form_e                   form;
  logic [LANES*BANK_W-1:0] bank_hash;
  logic [LANES*BANK_W-1:0] bank_d;
  logic [LANES*BANK_W-1:0] bank_q;
  logic                    valid_d;
  logic                    valid_q;
  logic                    eq_any;

  assign form = form_e'(rev_sel);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bxm_lane_hash #(
      .IDX_W (IDX_W),
      .BANK_W(BANK_W)
    ) u_hash (
      .rev (form == FORM_REV),
      .idx (idx_flat[k*IDX_W +: IDX_W]),
      .bank(bank_hash[k*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    valid_d = in_valid;
    bank_d  = bank_q;
    if (in_valid) begin
      bank_d = bank_hash;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bank_q  <= '0;
    end else begin
      valid_q <= valid_d;
      bank_q  <= bank_d;
    end
  end

  bxm_pair_cmp #(
    .BANK_W(BANK_W),
    .LANES (LANES)
  ) u_cmp (
    .banks (bank_q),
    .any_eq(eq_any)
  );

  assign out_valid = valid_q;
  assign bank_flat = bank_q;
  assign dup_flag  = valid_q & eq_any;
endmodule

// File: rtl/bank_xor_mapper_chk.sv
module bank_xor_mapper_chk #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned BANK_W = 4,
  localparam int unsigned LANES = 1 << BANK_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    rev_sel,
  input logic [LANES*IDX_W-1:0]  idx_flat,
  input logic                    out_valid,
  input logic [LANES*BANK_W-1:0] bank_flat,
  input logic                    dup_flag
);
  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R9
  hold_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(bank_flat));

  // R10
  dup_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_flag |-> out_valid);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !dup_flag));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R2
    bit0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> bank_flat[k*BANK_W] == $past(idx_flat[k*IDX_W]));
  end
endmodule

bind bank_xor_mapper bank_xor_mapper_chk #(
  .IDX_W (IDX_W),
  .BANK_W(BANK_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .rev_sel  (rev_sel),
  .idx_flat (idx_flat),
  .out_valid(out_valid),
  .bank_flat(bank_flat),
  .dup_flag (dup_flag)
);

// File: tb/bank_xor_mapper_bench.sv
module bank_xor_mapper_bench;
  localparam int N  = 8;
  localparam int B  = 4;
  localparam int L  = 1 << B;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic           rev_sel;
  logic [L*N-1:0] idx_flat;
  logic           out_valid;
  logic [L*B-1:0] bank_flat;
  logic           dup_flag;

  int tests;
  int fails;

  typedef struct {
    logic [L*B-1:0] banks;
    logic           dup;
    logic           rev;
  } exp_t;

  exp_t           sb[$];
  logic [L*B-1:0] last_banks;
  logic           mon_on;

  bank_xor_mapper #(.IDX_W(N), .BANK_W(B)) u_bank_xor_mapper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rev_sel(rev_sel),
    .idx_flat(idx_flat), .out_valid(out_valid), .bank_flat(bank_flat),
    .dup_flag(dup_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [B-1:0] model_bank(logic [N-1:0] a, logic rev);
    logic [B-1:0] r;
    logic plo;
    logic phi;
    plo = 1'b0;
    phi = 1'b0;
    for (int t = 1; t <= N - B + 1; t++) plo ^= a[t];
    for (int t = B - 1; t <= N - 1; t++) phi ^= a[t];
    r[0] = a[0];
    r[1] = rev ? phi : plo;
    r[B-1] = rev ? plo : phi;
    for (int t = 2; t <= B - 2; t++)
      r[t] = rev ? (a[N-t] ^ a[B-t]) : (a[t] ^ a[N-B+t]);
    return r;
  endfunction

  function automatic string bit_req(int bi, logic rev);
    if (bi == 0) return "R2";
    if (bi == 1) return rev ? "R6" : "R3";
    if (bi == B - 1) return rev ? "R8" : "R5";
    return rev ? "R7" : "R4";
  endfunction

  task automatic drive(input logic [L*N-1:0] ix, input logic rv);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    rev_sel  = rv;
    idx_flat = ix;
    for (int k = 0; k < L; k++)
      e.banks[k*B +: B] = model_bank(ix[k*N +: N], rv);
    e.dup = 1'b0;
    for (int i = 0; i < L; i++)
      for (int j = 0; j < i; j++)
        if (e.banks[i*B +: B] == e.banks[j*B +: B]) e.dup = 1'b1;
    e.rev = rv;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      in_valid = 1'b0;
      rev_sel  = ~rev_sel;
      idx_flat = {L{8'hA5}};
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          tests++; fails++;
          $display("FAIL R9: out_valid=1 actual, expected 0 (no pending group)");
        end else begin
          exp_t e;
          e = sb.pop_front();
          for (int k = 0; k < L; k++)
            for (int bi = 0; bi < B; bi++) begin
              tests++;
              if (bank_flat[k*B+bi] !== e.banks[k*B+bi]) begin
                fails++;
                $display("FAIL %s: lane %0d bit %0d actual %0b expected %0b",
                         bit_req(bi, e.rev), k, bi, bank_flat[k*B+bi], e.banks[k*B+bi]);
              end
            end
          tests++;
          if (dup_flag !== e.dup) begin
            fails++;
            $display("FAIL R10: dup_flag actual %0b expected %0b", dup_flag, e.dup);
          end
          last_banks = e.banks;
        end
      end else begin
        tests++;
        if (bank_flat !== last_banks || dup_flag !== 1'b0) begin
          fails++;
          $display("FAIL R9: idle banks actual %h expected %h, dup %0b expected 0",
                   bank_flat, last_banks, dup_flag);
        end
      end
    end
  end

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [L*N-1:0] v;
    logic [L*B-1:0] chk;
    tests = 0; fails = 0; mon_on = 1'b0; last_banks = '0;
    rst_n = 1'b0; in_valid = 1'b0; rev_sel = 1'b0; idx_flat = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    tests++;
    if (out_valid !== 1'b0 || dup_flag !== 1'b0 || bank_flat !== '0) begin
      fails++;
      $display("FAIL R1: valid %0b dup %0b banks %h expected 0 0 0",
               out_valid, dup_flag, bank_flat);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after release
    tests++;
    if (out_valid !== 1'b0 || dup_flag !== 1'b0 || bank_flat !== '0) begin
      fails++;
      $display("FAIL R1: after release valid %0b dup %0b banks %h expected 0 0 0",
               out_valid, dup_flag, bank_flat);
    end
    mon_on = 1'b1;

    // R3 R4 R5: contiguous indices, natural form
    for (int k = 0; k < L; k++) v[k*N +: N] = N'(k);
    drive(v, 1'b0);
    // R6 R7 R8: same indices, mirrored form
    drive(v, 1'b1);
    idle(2);

    // R11: lanes vary bits 0,1,6,7 over a fixed middle pattern, both forms
    for (int form = 0; form < 2; form++) begin
      for (int k = 0; k < L; k++) begin
        logic [N-1:0] a;
        a = 8'b0011_0100;
        a[0] = k[0]; a[1] = k[1]; a[6] = k[2]; a[7] = k[3];
        v[k*N +: N] = a;
      end
      chk = '0;
      for (int k = 0; k < L; k++) chk[k*B +: B] = model_bank(v[k*N +: N], form[0]);
      for (int i = 0; i < L; i++)
        for (int j = 0; j < i; j++) begin
          tests++;
          if (chk[i*B +: B] == chk[j*B +: B]) begin
            fails++;
            $display("FAIL R11: lanes %0d,%0d share bank %0d expected distinct",
                     i, j, chk[i*B +: B]);
          end
        end
      drive(v, form[0]);
    end
    idle(1);

    // R10: all lanes equal, then exactly one colliding pair
    drive({L{8'h5B}}, 1'b0);
    for (int k = 0; k < L; k++) v[k*N +: N] = N'(k);
    v[3*N +: N] = v[9*N +: N];
    drive(v, 1'b1);
    idle(3);

    // R12: back-to-back groups alternating form, pseudo-random indices
    for (int g = 0; g < 40; g++) begin
      for (int k = 0; k < L; k++) v[k*N +: N] = N'($urandom);
      drive(v, g[0]);
    end
    idle(2);

    // R9: sparse groups with gaps
    for (int g = 0; g < 10; g++) begin
      for (int k = 0; k < L; k++) v[k*N +: N] = N'($urandom);
      drive(v, g[1]);
      idle(g % 3 + 1);
    end
    idle(2);

    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d groups never appeared, expected 0 pending", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule